// File: doc/BRIEF.md
# Cartridge IRQ Timer

This block is a programmable interrupt timer for a cartridge memory controller. An 8-bit prescaler feeds an 8-bit main counter, and both move in the same direction, up or down. The CPU sets the timer up through eight write offsets. These writes select the counting source, the direction and the prescaler width. They also load the prescaler and the main counter through a programmable XOR mask, and they enable, disable or acknowledge the interrupt request.

Four strobes can drive the counting, one per source:
- a CPU cycle tick, which counts one step;
- an A12 event from the video address bus, which counts eight steps;
- a video read at an address different from the last one seen, which counts two steps;
- a CPU write tick, which counts one step.

Only the source selected in the mode register has any effect. All steps owed for one clock are applied in that same clock.

The request line is driven by a three-state machine:
- `LINE_OFF`: the timer is disabled.
- `LINE_ARMED`: the timer is enabled and no request is pending.
- `LINE_FIRED`: the timer is enabled and a request is pending.

The transitions between the states are:
- T_ENABLE: `LINE_OFF` to `LINE_ARMED`, on an enabling write.
- T_WRAP: `LINE_ARMED` to `LINE_FIRED`, when the main counter wraps.
- T_DISABLE: `LINE_ARMED` to `LINE_OFF`, on a disabling write.
- T_ACK: `LINE_FIRED` to `LINE_OFF`, on a disabling write.

Every other combination holds the current state.

Top module: `cart_irq_timer`

## Requirements
- R1: While `rst_n` is low and right after it rises, `irq` is 0. Reset clears the mode, the XOR mask, the prescaler, the main counter and the enable to zero.
- R2: Mode register (offset 1) bits 7:6 set the direction: 01 counts up and 10 counts down. The codes 00 and 11 freeze both the prescaler and the main counter, and both keep their values until counting resumes.
- R3: Mode bits 1:0 select the source. Code 0 is `tick_cpu` (1 step), code 1 is `tick_a12` (8 steps), code 2 is `ppu_rd` (2 steps) and code 3 is `tick_wr` (1 step). Strobes from the sources that are not selected have no effect.
- R4: An `ppu_rd` strobe counts only when `ppu_addr` differs from the address of the previous `ppu_rd` strobe. The stored address starts at 0 after reset.
- R5: Mode bit 2 set makes the prescaler compare only its low 3 bits. When counting up, the main counter steps each time the compared prescaler bits become all zeros. When counting down, it steps each time they become all ones.
- R6: A main-counter wrap raises `irq` only while the timer is enabled. The wrap is from 0xFF up to 0x00, or from 0x00 down to 0xFF. A wrap while disabled leaves nothing pending for a later enable.
- R7: A write to offset 0 with data bit 0 set enables the timer. A write to offset 0 with data bit 0 clear disables the timer and clears `irq`. A write to offset 2 disables and clears. A write to offset 3 enables without clearing a pending `irq`.
- R8: A write to offset 6 stores the XOR mask. Writes to offset 4 load the prescaler, and writes to offset 5 load the main counter, each with the write data XOR the stored mask.
- R9: `irq` is a level that stays high until a disabling write. Further wraps, enabling writes and writes to offset 7 do not change it. A write to offset 7 has no effect on counting.
- R10: A disabling write wins over a wrap in the same clock. A write to offset 5 wins over a count step into the main counter in the same clock, and that step raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset 0 to 7 |
| wr_data | input | 8 | Register write data |
| tick_cpu | input | 1 | CPU cycle strobe (source 0) |
| tick_a12 | input | 1 | A12 event strobe (source 1) |
| ppu_rd | input | 1 | Video read strobe (source 2) |
| ppu_addr | input | 14 | Address of the video read |
| tick_wr | input | 1 | CPU write strobe (source 3) |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of functions can land in the same clock.
- A wrap can coincide with a disabling write. The bench provokes this by driving `tick_cpu` together with an offset-2 write when the next step must wrap. It judges the result by `irq` staying low afterwards.
- A count step into the main counter can coincide with a main-counter load. The bench drives a tick that would wrap together with an offset-5 write of 0xFF. It then shows that the loaded value survived: after the prescaler is reloaded, a single further tick must wrap and raise `irq`.

// File: rtl/cart_irq_timer_pkg.sv
package cart_irq_timer_pkg;

    // register offsets whose meaning the control logic decodes
    localparam logic [2:0] OFS_ENABLE  = 3'd0;
    localparam logic [2:0] OFS_MODE    = 3'd1;
    localparam logic [2:0] OFS_DISABLE = 3'd2;
    localparam logic [2:0] OFS_ARM     = 3'd3;
    localparam logic [2:0] OFS_PRE     = 3'd4;
    localparam logic [2:0] OFS_CNT     = 3'd5;
    localparam logic [2:0] OFS_XOR     = 3'd6;

    typedef enum logic [1:0] {
        SRC_CPU   = 2'd0,
        SRC_A12   = 2'd1,
        SRC_RDCHG = 2'd2,
        SRC_WRITE = 2'd3
    } clk_src_t;

    typedef enum logic [1:0] {
        LINE_OFF   = 2'd0,
        LINE_ARMED = 2'd1,
        LINE_FIRED = 2'd2
    } line_state_t;

endpackage

// File: rtl/cart_irq_src_sel.sv
module cart_irq_src_sel
    import cart_irq_timer_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int A12_STEPS = 8,
    parameter int RD_STEPS  = 2,
    parameter int STEP_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              tick_cpu,
    input  logic              tick_a12,
    input  logic              ppu_rd,
    input  logic [ADDR_W-1:0] ppu_addr,
    input  logic              tick_wr,
    output logic [STEP_W-1:0] steps
);

    logic [ADDR_W-1:0] last_addr_q;
    logic              rd_new;

    assign rd_new = ppu_rd && (ppu_addr != last_addr_q);

    // address history is tracked whichever source is selected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_addr_q <= '0;
        else if (ppu_rd)
            last_addr_q <= ppu_addr;
    end

    always_comb begin
        unique case (clk_src_t'(sel))
            SRC_CPU:   steps = tick_cpu ? STEP_W'(1) : '0;
            SRC_A12:   steps = tick_a12 ? STEP_W'(A12_STEPS) : '0;
            SRC_RDCHG: steps = rd_new   ? STEP_W'(RD_STEPS) : '0;
            SRC_WRITE: steps = tick_wr  ? STEP_W'(1) : '0;
            default:   steps = '0;
        endcase
    end

endmodule

// File: rtl/cart_irq_step_chain.sv
module cart_irq_step_chain #(
    parameter int PRE_W     = 8,
    parameter int CNT_W     = 8,
    parameter int NARROW_W  = 3,
    parameter int MAX_STEPS = 8,
    parameter int STEP_W    = 4
) (
    input  logic [PRE_W-1:0]  pre_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              up,
    input  logic              down,
    input  logic              narrow,
    input  logic [STEP_W-1:0] steps,
    output logic [PRE_W-1:0]  pre_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              wrap
);

    localparam logic [PRE_W-1:0] NARROW_MASK = PRE_W'((1 << NARROW_W) - 1);

    logic [PRE_W-1:0] mask;
    logic [PRE_W-1:0] pre_s [MAX_STEPS+1];
    logic [CNT_W-1:0] cnt_s [MAX_STEPS+1];
    logic [MAX_STEPS:0] wrap_s;

    assign mask      = narrow ? NARROW_MASK : '1;
    assign pre_s[0]  = pre_in;
    assign cnt_s[0]  = cnt_in;
    assign wrap_s[0] = 1'b0;

    // one unrolled stage per possible prescaler step in a clock
    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_stage
        localparam logic [STEP_W-1:0] IDX = STEP_W'(g);
        logic             active;
        logic             carry;
        logic             hit;
        logic [PRE_W-1:0] pn;
        logic [CNT_W-1:0] cn;

        assign active = (up || down) && (steps > IDX);
        assign pn     = up ? pre_s[g] + 1'b1 : pre_s[g] - 1'b1;
        assign carry  = up ? ((pn & mask) == '0) : ((pn & mask) == mask);
        assign cn     = up ? cnt_s[g] + 1'b1 : cnt_s[g] - 1'b1;
        assign hit    = up ? (cn == '0) : (cn == '1);

        assign pre_s[g+1]  = active ? pn : pre_s[g];
        assign cnt_s[g+1]  = (active && carry) ? cn : cnt_s[g];
        assign wrap_s[g+1] = wrap_s[g] | (active && carry && hit);
    end

    assign pre_out = pre_s[MAX_STEPS];
    assign cnt_out = cnt_s[MAX_STEPS];
    assign wrap    = wrap_s[MAX_STEPS];

endmodule

// File: rtl/cart_irq_line.sv
module cart_irq_line
    import cart_irq_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic dis_wr,
    input  logic wrap,
    output logic irq
);

    line_state_t state_q;
    line_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LINE_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_OFF:   if (en_wr) state_d = LINE_ARMED;        // T_ENABLE
            LINE_ARMED: begin
                if (dis_wr)    state_d = LINE_OFF;              // T_DISABLE
                else if (wrap) state_d = LINE_FIRED;            // T_WRAP
            end
            LINE_FIRED: if (dis_wr) state_d = LINE_OFF;         // T_ACK
            default:    state_d = LINE_OFF;
        endcase
    end

    always_comb begin
        irq = (state_q == LINE_FIRED);
    end

endmodule

// File: rtl/cart_irq_timer.sv
module cart_irq_timer
    import cart_irq_timer_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 14,
    parameter int NARROW_W  = 3,
    parameter int A12_STEPS = 8,
    parameter int RD_STEPS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick_cpu,
    input  logic              tick_a12,
    input  logic              ppu_rd,
    input  logic [ADDR_W-1:0] ppu_addr,
    input  logic              tick_wr,
    output logic              irq
);

    localparam int MAX_STEPS = (A12_STEPS > RD_STEPS) ? A12_STEPS : RD_STEPS;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    logic [1:0]        dir_q;
    logic              narrow_q;
    logic [1:0]        src_q;
    logic [DATA_W-1:0] xor_q;
    logic [DATA_W-1:0] pre_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] pre_nx;
    logic [DATA_W-1:0] cnt_nx;
    logic [STEP_W-1:0] steps;
    logic              chain_wrap;
    logic              wrap_hit;
    logic              wr_mode, wr_pre, wr_cnt, wr_xor;
    logic              en_wr, dis_wr;

    assign wr_mode = wr_en && (wr_addr == OFS_MODE);
    assign wr_pre  = wr_en && (wr_addr == OFS_PRE);
    assign wr_cnt  = wr_en && (wr_addr == OFS_CNT);
    assign wr_xor  = wr_en && (wr_addr == OFS_XOR);
    assign en_wr   = wr_en && (((wr_addr == OFS_ENABLE) && wr_data[0]) ||
                               (wr_addr == OFS_ARM));
    assign dis_wr  = wr_en && (((wr_addr == OFS_ENABLE) && !wr_data[0]) ||
                               (wr_addr == OFS_DISABLE));

    // a load of the main counter discards any step into it this clock
    assign wrap_hit = chain_wrap && !wr_cnt;

    cart_irq_src_sel #(
        .ADDR_W    (ADDR_W),
        .A12_STEPS (A12_STEPS),
        .RD_STEPS  (RD_STEPS),
        .STEP_W    (STEP_W)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (src_q),
        .tick_cpu (tick_cpu),
        .tick_a12 (tick_a12),
        .ppu_rd   (ppu_rd),
        .ppu_addr (ppu_addr),
        .tick_wr  (tick_wr),
        .steps    (steps)
    );

    cart_irq_step_chain #(
        .PRE_W     (DATA_W),
        .CNT_W     (DATA_W),
        .NARROW_W  (NARROW_W),
        .MAX_STEPS (MAX_STEPS),
        .STEP_W    (STEP_W)
    ) u_chain (
        .pre_in  (pre_q),
        .cnt_in  (cnt_q),
        .up      (dir_q == 2'b01),
        .down    (dir_q == 2'b10),
        .narrow  (narrow_q),
        .steps   (steps),
        .pre_out (pre_nx),
        .cnt_out (cnt_nx),
        .wrap    (chain_wrap)
    );

    cart_irq_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (en_wr),
        .dis_wr (dis_wr),
        .wrap   (wrap_hit),
        .irq    (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '0;
            narrow_q <= 1'b0;
            src_q    <= '0;
            xor_q    <= '0;
            pre_q    <= '0;
            cnt_q    <= '0;
        end else begin
            if (wr_mode) begin
                dir_q    <= wr_data[7:6];
                narrow_q <= wr_data[2];
                src_q    <= wr_data[1:0];
            end
            if (wr_xor)
                xor_q <= wr_data;
            pre_q <= wr_pre ? (wr_data ^ xor_q) : pre_nx;
            cnt_q <= wr_cnt ? (wr_data ^ xor_q) : cnt_nx;
        end
    end

endmodule

// File: rtl/cart_irq_timer_chk.sv
module cart_irq_timer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic [1:0]        dir,
    input logic [DATA_W-1:0] pre,
    input logic [DATA_W-1:0] cnt,
    input logic              wrap_hit
);

    always @(posedge clk) begin
        if (!rst_n) begin
            // R1
            reset_quiet_chk: assert (!irq);
        end
    end

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ((wr_addr == 3'd2) || ((wr_addr == 3'd0) && !wr_data[0])) |=> !irq);

    // R9
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(wr_en && ((wr_addr == 3'd2) || ((wr_addr == 3'd0) && !wr_data[0])))
        |=> irq);

    // R6
    fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wrap_hit));

    // R2
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir != 2'b01) && (dir != 2'b10) &&
        !(wr_en && ((wr_addr == 3'd4) || (wr_addr == 3'd5)))
        |=> $stable(pre) && $stable(cnt));

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == 3'd5) && !irq |=> !irq);

endmodule

bind cart_irq_timer cart_irq_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq      (irq),
    .dir      (dir_q),
    .pre      (pre_q),
    .cnt      (cnt_q),
    .wrap_hit (wrap_hit)
);

// File: tb/sim_cart_irq_timer.sv
`timescale 1ns/1ps
module sim_cart_irq_timer;

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] xr;
        logic [7:0] pre;
        logic [7:0] cnt;
        logic [3:0] n;
    } vec_t;

    // mode, xor, raw prescaler write, raw counter write, strobes to wrap
    localparam vec_t VECS [9] = '{
        '{8'h40, 8'h00, 8'hFE, 8'hFF, 4'd2},   // R5 up, 8-bit, cpu
        '{8'h80, 8'h00, 8'h01, 8'h00, 4'd2},   // R5 down, 8-bit, cpu
        '{8'h44, 8'h00, 8'h05, 8'hFF, 4'd3},   // R5 up, 3-bit
        '{8'h84, 8'h00, 8'h12, 8'h00, 4'd3},   // R5 down, 3-bit
        '{8'h40, 8'h0F, 8'hF1, 8'hF0, 4'd2},   // R8 xor mask
        '{8'h41, 8'h00, 8'hF0, 8'hFF, 4'd2},   // R3 a12, 8 steps
        '{8'h45, 8'h00, 8'h00, 8'hFE, 4'd2},   // R3 a12, 3-bit
        '{8'h43, 8'h00, 8'hFF, 8'hFF, 4'd1},   // R3 write source
        '{8'h42, 8'h00, 8'hFC, 8'hFF, 4'd2}    // R3 read-change, 2 steps
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tick_cpu = 1'b0;
    logic        tick_a12 = 1'b0;
    logic        ppu_rd = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        tick_wr = 1'b0;
    logic        irq;
    logic [13:0] rd_seq = 14'h100;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    cart_irq_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_cpu(tick_cpu), .tick_a12(tick_a12),
        .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .tick_wr(tick_wr), .irq(irq)
    );

    task automatic check(input logic exp, input string tag);
        n_chk++;
        if (irq !== exp) begin
            n_err++;
            $display("FAIL %s: irq=%0b expected %0b", tag, irq, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; tick_cpu = 1'b0; tick_a12 = 1'b0;
        ppu_rd = 1'b0; tick_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse(input logic [1:0] src);
        @(negedge clk);
        case (src)
            2'd0: tick_cpu = 1'b1;
            2'd1: tick_a12 = 1'b1;
            2'd2: begin ppu_rd = 1'b1; ppu_addr = rd_seq; rd_seq++; end
            default: tick_wr = 1'b1;
        endcase
        @(negedge clk);
        idle();
    endtask

    task automatic rd_at(input logic [13:0] a);
        @(negedge clk);
        ppu_rd = 1'b1; ppu_addr = a;
        @(negedge clk);
        idle();
    endtask

    task automatic setup(input logic [7:0] m, input logic [7:0] x,
                         input logic [7:0] p, input logic [7:0] c);
        wr(3'd2, 8'h00);
        wr(3'd6, x);
        wr(3'd4, p);
        wr(3'd5, c);
        wr(3'd1, m);
        wr(3'd3, 8'h00);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, "R1 irq low during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 irq low after reset");
        wr(3'd3, 8'h00);
        pulse(2'd0); pulse(2'd0);
        check(1'b0, "R1 reset mode frozen");

        // table walk
        for (int i = 0; i < 9; i++) begin
            setup(VECS[i].mode, VECS[i].xr, VECS[i].pre, VECS[i].cnt);
            for (int k = 0; k < int'(VECS[i].n) - 1; k++) pulse(VECS[i].mode[1:0]);
            check(1'b0, $sformatf("R5 R3 vector %0d before wrap", i));
            pulse(VECS[i].mode[1:0]);
            check(1'b1, $sformatf("R6 R8 vector %0d at wrap", i));
        end

        // R2 frozen codes hold state, then resume
        setup(8'h00, 8'h00, 8'hFF, 8'hFF);
        pulse(2'd0); pulse(2'd0); pulse(2'd0);
        check(1'b0, "R2 dir 00 frozen");
        wr(3'd1, 8'hC0);
        pulse(2'd0); pulse(2'd0);
        check(1'b0, "R2 dir 11 frozen");
        wr(3'd1, 8'h40);
        pulse(2'd0);
        check(1'b1, "R2 state held through freeze");

        // R3 unselected sources ignored
        setup(8'h41, 8'h00, 8'hFF, 8'hFF);
        pulse(2'd0); pulse(2'd2); pulse(2'd3);
        check(1'b0, "R3 unselected strobes ignored");
        pulse(2'd1);
        check(1'b1, "R3 selected a12 strobe");

        // R4 repeated read address ignored
        setup(8'h42, 8'h00, 8'hFC, 8'hFF);
        rd_at(14'h3A5); rd_at(14'h3A5); rd_at(14'h3A5);
        check(1'b0, "R4 same address no count");
        rd_at(14'h3A6);
        check(1'b1, "R4 new address counts");

        // R6 wrap while disabled
        setup(8'h40, 8'h00, 8'hFF, 8'hFF);
        wr(3'd2, 8'h00);
        pulse(2'd0);
        check(1'b0, "R6 wrap while disabled");
        wr(3'd3, 8'h00);
        check(1'b0, "R6 nothing pending after enable");

        // R7 / R9 level behaviour
        setup(8'h40, 8'h00, 8'hFF, 8'hFF);
        pulse(2'd0);
        check(1'b1, "R7 fired");
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); pulse(2'd0);
        check(1'b1, "R9 second wrap keeps level");
        wr(3'd3, 8'h00);
        check(1'b1, "R7 offset 3 does not ack");
        wr(3'd0, 8'h01);
        check(1'b1, "R7 offset 0 bit1 does not ack");
        wr(3'd7, 8'hFF);
        check(1'b1, "R9 offset 7 no effect on level");
        wr(3'd0, 8'h00);
        check(1'b0, "R7 offset 0 bit0 clear acks");
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); pulse(2'd0);
        check(1'b0, "R7 offset 0 clear also disables");
        wr(3'd0, 8'h01);
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); pulse(2'd0);
        check(1'b1, "R7 offset 0 bit set enables");
        wr(3'd2, 8'h00);
        check(1'b0, "R7 offset 2 acks");

        // R9 offset 7 no effect on counting
        setup(8'h40, 8'h00, 8'hFE, 8'hFF);
        wr(3'd7, 8'hFF);
        pulse(2'd0);
        wr(3'd7, 8'h00);
        check(1'b0, "R9 offset 7 counting unchanged before wrap");
        pulse(2'd0);
        check(1'b1, "R9 offset 7 counting unchanged at wrap");

        // R10 disable wins over same-clock wrap
        setup(8'h40, 8'h00, 8'hFF, 8'hFF);
        @(negedge clk);
        tick_cpu = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h00;
        @(negedge clk);
        idle();
        check(1'b0, "R10 disable beats wrap");
        wr(3'd3, 8'h00);
        check(1'b0, "R10 no pending after re-enable");

        // R10 load of main counter beats same-clock step
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        @(negedge clk);
        tick_cpu = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'hFF;
        @(negedge clk);
        idle();
        check(1'b0, "R10 load beats step");
        wr(3'd4, 8'hFF);
        pulse(2'd0);
        check(1'b1, "R10 loaded value kept");

        // R1 reset while pending
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1'b0, "R1 async reset clears irq");
        @(negedge clk);
        rst_n = 1'b1;
        wr(3'd3, 8'h00);
        pulse(2'd0); pulse(2'd0);
        check(1'b0, "R1 registers cleared by reset");

        finish_run();
    end

endmodule